// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This unit holds a small bank of 64-bit control and status registers and performs atomic read-modify-write requests on them. A request names one register, an operation kind (write, set bits, clear bits) and an operand source. The operand is either the rs1 value or a 5-bit immediate that is zero-extended to 64 bits. The unit returns the value the register held before the request, for the destination register. In the same clock cycle it computes the new value and commits it on the next rising edge.

The bank has a parameterised number of generic scratch registers at consecutive addresses and one read-only, free-running cycle counter. A set or clear whose operand is flagged as zero (rs1 is x0, or the immediate is zero) is a pure read, so the counter can be read without error. Any attempt to change the counter, any unimplemented address and the reserved operation kind raise an error flag and change nothing. Privilege checks and traps are left to the surrounding pipeline.

Top module: `csr_rmw_unit`

## Requirements
- R1: With `req_valid` high and no error, `rd_val` shows, in the same cycle, the value the addressed register held before this request. Scratch register i sits at address 0x340+i for i = 0..3, and the cycle counter sits at address 0xC00.
- R2: Kind 2'b00 (write) replaces the addressed scratch register with the operand at the next rising edge.
- R3: Kind 2'b01 (set) stores the old value ORed with the operand.
- R4: Kind 2'b10 (clear) stores the old value ANDed with the inverted operand.
- R5: With `req_use_imm` = 1, the operand is `req_imm` zero-extended to 64 bits, and `req_rs1` is ignored.
- R6: A set or clear whose zero flag is raised performs no write but still returns the old value. The zero flag is `req_rs1_is_x0` for the register form and `req_imm_is_zero` for the immediate form, whatever the operand value is.
- R7: The cycle counter is cleared by reset and increases by one on every rising edge while out of reset. A set or clear on it with a raised zero flag reads it without error.
- R8: `err` rises, `rd_val` is 0 and no register changes in these cases: an unimplemented address, kind 2'b11, a write kind to the counter, or a set or clear on the counter with the zero flag low.
- R9: With `req_valid` low, `rd_val` is 0, `err` is 0 and nothing is written.
- R10: Reset (`rst_n` low) clears every scratch register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_kind | input | 2 | 00 write, 01 set, 10 clear, 11 reserved |
| req_use_imm | input | 1 | Select the immediate as operand |
| req_rs1 | input | 64 | Register operand |
| req_imm | input | 5 | Immediate operand |
| req_rs1_is_x0 | input | 1 | Register operand comes from x0 |
| req_imm_is_zero | input | 1 | Immediate operand is zero |
| rd_val | output | 64 | Pre-write value of the addressed register |
| err | output | 1 | Request rejected |

## Verification
Each operation kind is applied to a scratch register that already holds a mixed bit pattern. This makes write, set and clear produce three different results: a swapped kind gives a wrong value on the next read. Operand-source tests put a nonzero value on the unused operand, and zero-flag tests pair a raised flag with a nonzero operand. These show whether the right source and the right flag are used. Counter reads spaced by known idle gaps separate a stalled or reset-ignoring counter from a correct one. Rejected requests are each followed by a read-back to confirm that nothing moved.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  localparam int unsigned CSR_W = 64;
  typedef logic [CSR_W-1:0] csr_word_t;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'b00,
    KIND_SET   = 2'b01,
    KIND_CLEAR = 2'b10,
    KIND_RSVD  = 2'b11
  } csr_kind_e;

  // New register value for a given kind, old value and operand.
  function automatic csr_word_t csr_merge(input csr_kind_e kind,
                                          input csr_word_t old_v,
                                          input csr_word_t opnd);
    case (kind)
      KIND_WRITE: csr_merge = opnd;
      KIND_SET:   csr_merge = old_v | opnd;
      KIND_CLEAR: csr_merge = old_v & ~opnd;
      default:    csr_merge = old_v;
    endcase
  endfunction

  // Zero-extend an immediate of any width up to a full word.
  function automatic csr_word_t csr_zext(input logic [CSR_W-1:0] narrow);
    csr_zext = narrow;
  endfunction
endpackage

// File: rtl/csr_operand_sel.sv
module csr_operand_sel
  import csr_rmw_pkg::*;
#(
  parameter int unsigned IMM_W = 5
) (
  input  logic             use_imm,
  input  csr_word_t        rs1_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             rs1_is_x0,
  input  logic             imm_is_zero,
  output csr_word_t        operand,
  output logic             mask_zero
);
  localparam int unsigned PAD_W = CSR_W - IMM_W;

  csr_word_t imm_ext;

  always_comb begin
    imm_ext   = csr_zext({{PAD_W{1'b0}}, imm_val});
    operand   = use_imm ? imm_ext : rs1_val;
    mask_zero = use_imm ? imm_is_zero : rs1_is_x0;
  end
endmodule

// File: rtl/csr_scratch_bank.sv
module csr_scratch_bank
  import csr_rmw_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  csr_word_t                wr_data,
  output logic [NUM_REGS-1:0][CSR_W-1:0] regs_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (sel) regs_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/csr_cycle_ctr.sv
module csr_cycle_ctr
  import csr_rmw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  output csr_word_t count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned IMM_W        = 5,
  parameter int unsigned NUM_SCRATCH  = 4,
  parameter int unsigned SCRATCH_BASE = 12'h340,
  parameter int unsigned CYCLE_ADDR   = 12'hC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_use_imm,
  input  logic [CSR_W-1:0]  req_rs1,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic              req_rs1_is_x0,
  input  logic              req_imm_is_zero,
  output logic [CSR_W-1:0]  rd_val,
  output logic              err
);
  localparam int unsigned IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

  csr_kind_e                         kind;
  csr_word_t                         operand;
  logic                              mask_zero;
  logic [NUM_SCRATCH-1:0][CSR_W-1:0] scratch_q;
  csr_word_t                         cycle_q;
  logic [ADDR_W-1:0]                 addr_off;
  logic                              hit_scratch;
  logic                              hit_cycle;
  logic                              wants_write;
  logic                              err_evt;
  logic [IDX_W-1:0]                  wr_idx;
  csr_word_t                         old_val;
  csr_word_t                         wr_data;
  logic                              wr_en;

  assign kind = csr_kind_e'(req_kind);

  csr_operand_sel #(.IMM_W(IMM_W)) u_opsel (
    .use_imm     (req_use_imm),
    .rs1_val     (req_rs1),
    .imm_val     (req_imm),
    .rs1_is_x0   (req_rs1_is_x0),
    .imm_is_zero (req_imm_is_zero),
    .operand     (operand),
    .mask_zero   (mask_zero)
  );

  always_comb begin
    addr_off    = req_addr - ADDR_W'(SCRATCH_BASE);
    hit_scratch = req_valid && (req_addr >= ADDR_W'(SCRATCH_BASE))
                  && (addr_off < ADDR_W'(NUM_SCRATCH));
    hit_cycle   = req_valid && (req_addr == ADDR_W'(CYCLE_ADDR));
    wr_idx      = addr_off[IDX_W-1:0];
    wants_write = (kind == KIND_WRITE) || !mask_zero;
    err_evt     = req_valid && (!(hit_scratch || hit_cycle)
                  || (kind == KIND_RSVD)
                  || (hit_cycle && wants_write));
    if (hit_scratch)    old_val = scratch_q[wr_idx];
    else if (hit_cycle) old_val = cycle_q;
    else                old_val = '0;
    wr_en   = hit_scratch && !err_evt && wants_write;
    wr_data = csr_merge(kind, old_val, operand);
    rd_val  = err_evt ? '0 : old_val;
    err     = err_evt;
  end

  csr_scratch_bank #(.NUM_REGS(NUM_SCRATCH), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_q  (scratch_q)
  );

  csr_cycle_ctr u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_q (cycle_q)
  );
endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker
  import csr_rmw_pkg::*;
#(
  parameter int unsigned NUM_SCRATCH = 4,
  parameter int unsigned IDX_W       = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic [1:0]                        req_kind,
  input logic                              req_use_imm,
  input logic                              req_rs1_is_x0,
  input logic                              req_imm_is_zero,
  input logic [CSR_W-1:0]                  rd_val,
  input logic                              err,
  input logic                              wr_en,
  input logic [IDX_W-1:0]                  wr_idx,
  input logic [CSR_W-1:0]                  wr_data,
  input logic [NUM_SCRATCH-1:0][CSR_W-1:0] scratch_q,
  input logic [CSR_W-1:0]                  cycle_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rd_val == '0 && !err && !wr_en)); // R9

  AST_ZERO_MASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b00
     && (req_use_imm ? req_imm_is_zero : req_rs1_is_x0)) |-> !wr_en); // R6

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en); // R8

  AST_ERR_ZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rd_val == '0); // R8

  AST_ERR_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(scratch_q)); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> scratch_q[$past(wr_idx)] == $past(wr_data)); // R2

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_q == $past(cycle_q) + 1'b1); // R7
endmodule

bind csr_rmw_unit csr_rmw_checker #(
  .NUM_SCRATCH (NUM_SCRATCH),
  .IDX_W       (IDX_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_kind        (req_kind),
  .req_use_imm     (req_use_imm),
  .req_rs1_is_x0   (req_rs1_is_x0),
  .req_imm_is_zero (req_imm_is_zero),
  .rd_val          (rd_val),
  .err             (err),
  .wr_en           (wr_en),
  .wr_idx          (wr_idx),
  .wr_data         (wr_data),
  .scratch_q       (scratch_q),
  .cycle_q         (cycle_q)
);

// File: tb/csr_rmw_unit_bench.sv
module csr_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_use_imm = 1'b0;
  logic [63:0] req_rs1 = '0;
  logic [4:0]  req_imm = '0;
  logic        req_rs1_is_x0 = 1'b0;
  logic        req_imm_is_zero = 1'b0;
  logic [63:0] rd_val;
  logic        err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] rd;
    logic        er;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [63:0] mdl [4];
  logic [63:0] cyc_mdl = '0;

  always #10 clk = ~clk;

  csr_rmw_unit u_csr_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_use_imm(req_use_imm), .req_rs1(req_rs1),
    .req_imm(req_imm), .req_rs1_is_x0(req_rs1_is_x0),
    .req_imm_is_zero(req_imm_is_zero), .rd_val(rd_val), .err(err)
  );

  // Counter expectation per R7: cleared in reset, +1 on each edge after.
  always @(posedge clk) begin
    if (!rst_n) cyc_mdl <= '0;
    else        cyc_mdl <= cyc_mdl + 64'd1;
  end

  // Monitor: compare each active request at the falling edge.
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request output rd=%h err=%b", rd_val, err);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rd_val !== e.rd || err !== e.er) begin
          errors++;
          $display("FAIL %s: rd=%h err=%b expected rd=%h err=%b",
                   e.tag, rd_val, err, e.rd, e.er);
        end
      end
    end
  end

  // Driver: called just after a rising edge; holds the request one cycle.
  task automatic do_req(input string tag, input logic [11:0] a,
                        input logic [1:0] k, input logic im,
                        input logic [63:0] r, input logic [4:0] i,
                        input logic x0, input logic iz);
    logic        scr, cyc, zf, er;
    logic [63:0] opnd, rdv;
    int          idx;
    exp_t        e;
    scr  = (a >= 12'h340) && (a <= 12'h343);
    cyc  = (a == 12'hC00);
    idx  = int'(a - 12'h340);
    opnd = im ? {59'd0, i} : r;
    zf   = im ? iz : x0;
    er   = !(scr || cyc) || (k == 2'b11) || (cyc && (k == 2'b00 || !zf));
    rdv  = er ? 64'd0 : (scr ? mdl[idx] : cyc_mdl);
    e.rd = rdv; e.er = er; e.tag = tag;
    exp_q.push_back(e);
    if (!er && scr && !(k != 2'b00 && zf)) begin
      case (k)
        2'b00:   mdl[idx] = opnd;
        2'b01:   mdl[idx] = mdl[idx] | opnd;
        default: mdl[idx] = mdl[idx] & ~opnd;
      endcase
    end
    req_valid = 1'b1; req_addr = a; req_kind = k; req_use_imm = im;
    req_rs1 = r; req_imm = i; req_rs1_is_x0 = x0; req_imm_is_zero = iz;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd_scr(input string tag, input int n);
    do_req(tag, 12'h340 + 12'(n), 2'b01, 1'b0, 64'hFFFF_0000_FFFF_0000, 5'd0, 1'b1, 1'b0);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    checks++;
    if (rd_val !== 64'd0 || err !== 1'b0) begin
      errors++;
      $display("FAIL %s: rd=%h err=%b expected rd=0 err=0", tag, rd_val, err);
    end
    @(posedge clk); #1;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) mdl[n] = '0;
    @(posedge clk); #1;
  endtask

  task automatic run_tests();
    apply_reset();
    idle_check("R9 idle after reset");
    for (int n = 0; n < 4; n++) rd_scr("R10 scratch zero after reset", n);
    do_req("R1 R2 write scratch0", 12'h340, 2'b00, 1'b0, 64'hDEAD_BEEF_0123_4567, 5'd3, 1'b0, 1'b0);
    do_req("R3 set scratch0", 12'h340, 2'b01, 1'b0, 64'h0000_0000_0000_F0F0, 5'd0, 1'b0, 1'b0);
    do_req("R4 clear scratch0", 12'h340, 2'b10, 1'b0, 64'hFFFF_0000_0000_00FF, 5'd0, 1'b0, 1'b0);
    rd_scr("R4 read scratch0 after clear", 0);
    do_req("R5 write imm scratch1", 12'h341, 2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, 5'h1F, 1'b0, 1'b0);
    do_req("R6 set imm zero flag", 12'h341, 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h0A, 1'b0, 1'b1);
    do_req("R6 clear reg x0 flag", 12'h341, 2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 1'b1, 1'b0);
    rd_scr("R6 scratch1 unchanged", 1);
    do_req("R5 R4 clear imm scratch1", 12'h341, 2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h05, 1'b0, 1'b0);
    do_req("R5 R3 set imm scratch1", 12'h341, 2'b01, 1'b1, 64'h0, 5'h04, 1'b1, 1'b0);
    rd_scr("R5 read scratch1", 1);
    do_req("R7 read counter", 12'hC00, 2'b01, 1'b0, 64'h5, 5'd0, 1'b1, 1'b0);
    idle_check("R9 idle gap");
    idle_check("R9 idle gap");
    do_req("R7 read counter imm clear", 12'hC00, 2'b10, 1'b1, 64'h0, 5'd0, 1'b0, 1'b1);
    do_req("R8 write counter", 12'hC00, 2'b00, 1'b0, 64'h0, 5'd0, 1'b1, 1'b0);
    do_req("R8 set counter nonzero", 12'hC00, 2'b01, 1'b1, 64'h0, 5'h01, 1'b0, 1'b0);
    do_req("R7 counter after rejects", 12'hC00, 2'b01, 1'b0, 64'h0, 5'd0, 1'b1, 1'b0);
    do_req("R8 unknown address", 12'h344, 2'b00, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 5'd0, 1'b0, 1'b0);
    do_req("R8 reserved kind", 12'h342, 2'b11, 1'b0, 64'h5555, 5'd0, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++) rd_scr("R8 bank unchanged", n);
    do_req("R2 b2b write scratch3 a", 12'h343, 2'b00, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 5'd0, 1'b0, 1'b0);
    do_req("R2 b2b write scratch3 b", 12'h343, 2'b00, 1'b0, 64'h8000_0000_0000_0001, 5'd0, 1'b0, 1'b0);
    do_req("R1 R3 set scratch3", 12'h343, 2'b01, 1'b0, 64'h0000_0001_0000_0000, 5'd0, 1'b0, 1'b0);
    rd_scr("R3 read scratch3", 3);
    apply_reset();
    rd_scr("R10 scratch0 cleared by reset", 0);
    rd_scr("R10 scratch3 cleared by reset", 3);
    do_req("R7 counter after reset", 12'hC00, 2'b01, 1'b0, 64'h0, 5'd0, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int n = 0; n < 4; n++) mdl[n] = '0;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %0d expected results never observed", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule